// File: doc/BRIEF.md
# I2C Register Transaction Bridge

This block sits between a byte-level I2C target engine and a word-oriented register bus inside a security-module front end. The engine reports five byte-level events: a write transfer begins, a read transfer begins, a byte was received, a byte must be supplied for transmission, and the transfer ended with a stop. The bridge turns these events into register-bus accesses. It decodes the first received byte as a register index. It buffers and packs multi-byte register writes. It streams data-FIFO bytes straight through. It takes a 32-bit snapshot when a register read begins and shifts it out one byte at a time.

The locality-select register and the checksum-enable register are held in the bridge and are never forwarded. Every other register address is formed from a base address plus the selected locality, placed at a fixed shift. The status register can be reached through any of four consecutive indices, one per byte lane. The lane sets both the write mask and the read alignment. All register-bus outputs are decoded combinationally from the current event and the bridge state, so read data is taken in the same cycle as the read strobe. The acknowledge and transmit-byte responses are registered and appear one cycle after their event.

Top module: `i2c_regbridge`

## Requirements
- R1: The first byte after a write start is an index. Accepted indices are 0x00 locality select, 0x04 access, 0x08 interrupt enable, 0x14 interrupt capability, 0x18 to 0x1B status lanes 0 to 3, 0x24 data FIFO, 0x30 interface capability, 0x40 checksum enable, 0x48 device/vendor id and 0x4C revision. Any other index, including 0x38 (device address change), gets rx_nak high in the cycle after the byte.
- R2: The downstream address is base + (locality << 12). The bases are: access 0x000, interrupt enable 0x008, interface capability 0x014, status 0x018, FIFO 0x024, id 0xF00, revision 0xF04. A status write also adds its lane.
- R3: Data bytes written to a forwarded non-FIFO register are held until stop. At stop they make exactly one write with dn_size = 4, assembled least-significant byte first, with missing bytes as zero. No write occurs before the stop.
- R4: Each data byte written to the FIFO index causes one immediate downstream write with dn_size = 1 and the byte in wdata[7:0]. The stop adds no write.
- R5: A locality-select write sets the locality only if the value is below 5. It never reaches the bus. A read of index 0x00 returns the locality.
- R6: A checksum-enable write keeps only bit 0 of its first data byte and never reaches the bus. A read returns that bit.
- R7: An interrupt-enable write is ANDed with 0x80000087. A read of the interrupt-capability index returns 0x80000087 without a bus read.
- R8: A status write through lane L is ANDed with 0x0700006E >> 8L and issued at status base + L.
- R9: The first transmit request after an index-only write performs one capture (at most one bus read, dn_size = 4) and returns byte 0 of the value. The next three requests return bytes 1 to 3 with no bus access. Later requests return 0xFF. A read start changes nothing.
- R10: A status read through lane L returns (raw & 0x03FFFFFF) >> 8L.
- R11: An interface-capability read returns 0x00081292, with bit 29 also set when bit 8 of the raw downstream word is set.
- R12: Every transmit byte for the FIFO index is a fresh one-byte downstream read, whose bits 7:0 are returned.
- R13: Reset clears the locality, checksum enable and transfer state. A write start or a stop clears the index, buffer and offset. A transmit request with no index pending returns 0xFF with no bus access.
- R14: A fifth data byte to a non-FIFO register is NAKed and is dropped from the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wr_start | input | 1 | Write transfer begins (start or repeated start) |
| ev_rd_start | input | 1 | Read transfer begins |
| ev_rx_valid | input | 1 | A byte was received |
| ev_rx_byte | input | 8 | Received byte |
| ev_tx_req | input | 1 | A transmit byte is requested |
| ev_stop | input | 1 | Transfer ended |
| rx_done | output | 1 | Response to a received byte is valid |
| rx_nak | output | 1 | Received byte is refused |
| tx_valid | output | 1 | tx_byte is valid |
| tx_byte | output | 8 | Byte to transmit |
| dn_addr | output | ADDR_W | Register-bus address |
| dn_wdata | output | 32 | Register-bus write data |
| dn_size | output | 3 | Access size in bytes (1 or 4) |
| dn_wr | output | 1 | Write strobe |
| dn_rd | output | 1 | Read strobe |
| dn_rdata | input | 32 | Read data, valid in the strobe cycle |

## Verification
The bench targets the boundaries where bytes stop being cached. It checks the fifth write byte, the fifth read byte and an index followed by a repeated write start. A bridge that miscounts its offset would either commit a stale or shifted word or read the bus again instead of returning 0xFF. Status lanes are tested at both ends: a lane-3 single-byte write must land at base + 3 with the top mask byte, and a lane-2 read must show bits 31:26 cleared before the shift. FIFO traffic must produce one bus access per byte in both directions. A bridge that cached FIFO data would return the same byte on every read. Locality writes with a value out of range must leave the earlier locality in place, and this shows up in later bus addresses.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

  typedef enum logic [1:0] {OP_IDLE, OP_SEND, OP_RECV} op_t;

  typedef enum logic [3:0] {
    K_NONE, K_LOCSEL, K_ACCESS, K_INTEN, K_INTCAP, K_STS, K_FIFO,
    K_IFCAP, K_DEVADDR, K_CSUMEN, K_DIDVID, K_RID
  } kind_t;

  typedef struct packed {
    kind_t       kind;
    logic [1:0]  lane;
    logic [11:0] base;
  } idx_info_t;

  // index codes seen on the serial side
  localparam logic [7:0] IX_LOCSEL  = 8'h00;
  localparam logic [7:0] IX_ACCESS  = 8'h04;
  localparam logic [7:0] IX_INTEN   = 8'h08;
  localparam logic [7:0] IX_INTCAP  = 8'h14;
  localparam logic [7:0] IX_STS     = 8'h18;
  localparam logic [7:0] IX_FIFO    = 8'h24;
  localparam logic [7:0] IX_IFCAP   = 8'h30;
  localparam logic [7:0] IX_DEVADDR = 8'h38;
  localparam logic [7:0] IX_CSUMEN  = 8'h40;
  localparam logic [7:0] IX_DIDVID  = 8'h48;
  localparam logic [7:0] IX_RID     = 8'h4C;

  // register-bus base offsets at locality 0
  localparam logic [11:0] BA_ACCESS = 12'h000;
  localparam logic [11:0] BA_INTEN  = 12'h008;
  localparam logic [11:0] BA_IFCAP  = 12'h014;
  localparam logic [11:0] BA_STS    = 12'h018;
  localparam logic [11:0] BA_FIFO   = 12'h024;
  localparam logic [11:0] BA_DIDVID = 12'hF00;
  localparam logic [11:0] BA_RID    = 12'hF04;

  localparam logic [31:0] INTEN_MASK  = 32'h8000_0087;
  localparam logic [31:0] STS_WR_MASK = 32'h0700_006E;
  localparam logic [31:0] STS_RD_MASK = 32'h03FF_FFFF;

  // interface capability pieces
  localparam logic [31:0] CAP_IF_TYPE  = 32'h0000_0002;
  localparam logic [31:0] CAP_IF_VER   = 32'h0000_0010;
  localparam logic [31:0] CAP_FAMILY   = 32'h0000_0080;
  localparam logic [31:0] CAP_LOCALITY = 32'h0000_0200;
  localparam logic [31:0] CAP_SPEED    = 32'h0000_1000;
  localparam logic [31:0] CAP_ADDR_CHG = 32'h0008_0000;
  localparam logic [31:0] CAP_BURST    = 32'h2000_0000;
  localparam int          RAW_BURST_BIT = 8;

  function automatic idx_info_t lookup_idx(input logic [7:0] ix);
    idx_info_t r;
    r.kind = K_NONE;
    r.lane = 2'd0;
    r.base = 12'h000;
    if (ix[7:2] == IX_STS[7:2]) begin
      r.kind = K_STS;
      r.lane = ix[1:0];
      r.base = BA_STS;
    end else begin
      case (ix)
        IX_LOCSEL:  r.kind = K_LOCSEL;
        IX_ACCESS:  begin r.kind = K_ACCESS; r.base = BA_ACCESS; end
        IX_INTEN:   begin r.kind = K_INTEN;  r.base = BA_INTEN;  end
        IX_INTCAP:  r.kind = K_INTCAP;
        IX_FIFO:    begin r.kind = K_FIFO;   r.base = BA_FIFO;   end
        IX_IFCAP:   begin r.kind = K_IFCAP;  r.base = BA_IFCAP;  end
        IX_DEVADDR: r.kind = K_DEVADDR;
        IX_CSUMEN:  r.kind = K_CSUMEN;
        IX_DIDVID:  begin r.kind = K_DIDVID; r.base = BA_DIDVID; end
        IX_RID:     begin r.kind = K_RID;    r.base = BA_RID;    end
        default:    r.kind = K_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] pack_le(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3);
    return {b3, b2, b1, b0};
  endfunction

  function automatic logic [31:0] sts_wr_mask(input logic [1:0] lane);
    return STS_WR_MASK >> (8 * lane);
  endfunction

  function automatic logic [31:0] sts_rd_shape(input logic [31:0] raw, input logic [1:0] lane);
    return (raw & STS_RD_MASK) >> (8 * lane);
  endfunction

  function automatic logic [31:0] ifcap_shape(input logic [31:0] raw);
    logic [31:0] v;
    v = CAP_IF_TYPE | CAP_IF_VER | CAP_FAMILY | CAP_LOCALITY | CAP_SPEED | CAP_ADDR_CHG;
    if (raw[RAW_BURST_BIT]) v = v | CAP_BURST;
    return v;
  endfunction

endpackage

// File: rtl/regbridge_idx_map.sv
module regbridge_idx_map
  import regbridge_pkg::*;
(
  input  logic [7:0] idx,
  output idx_info_t  info,
  output logic       accept
);
  always_comb begin
    info   = lookup_idx(idx);
    accept = (info.kind != K_NONE) && (info.kind != K_DEVADDR);
  end
endmodule

// File: rtl/regbridge_rd_shape.sv
module regbridge_rd_shape
  import regbridge_pkg::*;
#(
  parameter int LOC_W = 3
) (
  input  kind_t             kind,
  input  logic [1:0]        lane,
  input  logic [LOC_W-1:0]  loc,
  input  logic              csum_en,
  input  logic [31:0]       raw,
  output logic              need_rd,
  output logic [31:0]       value
);
  always_comb begin
    need_rd = 1'b0;
    value   = 32'h0;
    case (kind)
      K_LOCSEL: value = 32'(loc);
      K_CSUMEN: value = {31'h0, csum_en};
      K_INTCAP: value = INTEN_MASK;
      K_FIFO:   begin need_rd = 1'b1; value = {24'h0, raw[7:0]}; end
      K_STS:    begin need_rd = 1'b1; value = sts_rd_shape(raw, lane); end
      K_IFCAP:  begin need_rd = 1'b1; value = ifcap_shape(raw); end
      K_ACCESS, K_INTEN, K_DIDVID, K_RID: begin need_rd = 1'b1; value = raw; end
      default:  value = 32'h0;
    endcase
  end
endmodule

// File: rtl/regbridge_wr_pack.sv
module regbridge_wr_pack
  import regbridge_pkg::*;
(
  input  kind_t        kind,
  input  logic [1:0]   lane,
  input  logic [7:0]   b0,
  input  logic [7:0]   b1,
  input  logic [7:0]   b2,
  input  logic [7:0]   b3,
  output logic         fwd,
  output logic [31:0]  word
);
  logic [31:0] raw;
  always_comb begin
    raw  = pack_le(b0, b1, b2, b3);
    fwd  = 1'b0;
    word = raw;
    case (kind)
      K_INTEN: begin fwd = 1'b1; word = raw & INTEN_MASK; end
      K_STS:   begin fwd = 1'b1; word = raw & sts_wr_mask(lane); end
      K_ACCESS, K_IFCAP, K_DIDVID, K_RID: fwd = 1'b1;
      default: fwd = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_regbridge.sv
module i2c_regbridge
  import regbridge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5,
  parameter int BUF_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr_start,
  input  logic              ev_rd_start,
  input  logic              ev_rx_valid,
  input  logic [7:0]        ev_rx_byte,
  input  logic              ev_tx_req,
  input  logic              ev_stop,
  output logic              rx_done,
  output logic              rx_nak,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  output logic [2:0]        dn_size,
  output logic              dn_wr,
  output logic              dn_rd,
  input  logic [31:0]       dn_rdata
);
  localparam int LOC_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;
  localparam int OFF_W = $clog2(BUF_BYTES + 1);
  localparam logic [OFF_W-1:0] OFF_FULL = OFF_W'(BUF_BYTES);

  op_t              op_q;
  logic [OFF_W-1:0] off_q;
  logic [7:0]       buf_q [BUF_BYTES];
  idx_info_t        info_q;
  logic [LOC_W-1:0] loc_q;
  logic             csum_q;

  // decoded events, named for the checker
  idx_info_t   lk_info;
  logic        lk_ok;
  logic        rx_at_idx, rx_data, fifo_stream, store_byte, nak_d;
  logic        local_commit, bus_commit, snap, seq_rd, fifo_rd, clr;
  logic        wp_fwd, rs_need;
  logic [31:0] wp_word, rs_value;
  logic [7:0]  seq_byte;

  regbridge_idx_map u_map (
    .idx    (ev_rx_byte),
    .info   (lk_info),
    .accept (lk_ok)
  );

  regbridge_wr_pack u_wpack (
    .kind (info_q.kind),
    .lane (info_q.lane),
    .b0   (buf_q[1]),
    .b1   (buf_q[2]),
    .b2   (buf_q[3]),
    .b3   (buf_q[4]),
    .fwd  (wp_fwd),
    .word (wp_word)
  );

  regbridge_rd_shape #(.LOC_W(LOC_W)) u_rshape (
    .kind    (info_q.kind),
    .lane    (info_q.lane),
    .loc     (loc_q),
    .csum_en (csum_q),
    .raw     (dn_rdata),
    .need_rd (rs_need),
    .value   (rs_value)
  );

  always_comb begin
    rx_at_idx    = ev_rx_valid && (off_q == '0);
    rx_data      = ev_rx_valid && (off_q != '0);
    fifo_stream  = rx_data && (op_q == OP_SEND) && (info_q.kind == K_FIFO);
    store_byte   = rx_data && (op_q == OP_SEND) && (info_q.kind != K_FIFO) && (off_q < OFF_FULL);
    nak_d        = (rx_at_idx && !lk_ok) || (rx_data && !fifo_stream && !store_byte);
    local_commit = ev_stop && (op_q == OP_SEND) && (off_q > OFF_W'(1));
    bus_commit   = local_commit && wp_fwd;
    snap         = ev_tx_req && (op_q == OP_SEND) && (off_q == OFF_W'(1));
    seq_rd       = ev_tx_req && (op_q == OP_RECV) && (info_q.kind != K_FIFO) && (off_q < OFF_FULL);
    fifo_rd      = ev_tx_req && (op_q == OP_RECV) && (info_q.kind == K_FIFO);
    clr          = ev_wr_start || ev_stop;
  end

  always_comb begin
    seq_byte = 8'hFF;
    for (int i = 0; i < BUF_BYTES; i++)
      if (off_q == OFF_W'(i)) seq_byte = buf_q[i];
  end

  // register-bus side, decoded from the present event
  always_comb begin
    dn_wr    = fifo_stream || bus_commit;
    dn_rd    = (snap && rs_need) || fifo_rd;
    dn_wdata = fifo_stream ? {24'h0, ev_rx_byte} : wp_word;
    dn_addr  = ADDR_W'(info_q.base) + (ADDR_W'(loc_q) << LOC_SHIFT)
             + (bus_commit ? ADDR_W'(info_q.lane) : ADDR_W'(0));
    if (fifo_stream || fifo_rd || (snap && info_q.kind == K_FIFO)) dn_size = 3'd1;
    else if (dn_wr || dn_rd)                                       dn_size = 3'd4;
    else                                                           dn_size = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      off_q    <= '0;
      info_q   <= '0;
      loc_q    <= '0;
      csum_q   <= 1'b0;
      rx_done  <= 1'b0;
      rx_nak   <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= 8'h00;
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'h00;
    end else begin
      rx_done  <= ev_rx_valid;
      rx_nak   <= nak_d;
      tx_valid <= ev_tx_req;
      if (local_commit && info_q.kind == K_LOCSEL && buf_q[1] < 8'(NUM_LOC))
        loc_q <= LOC_W'(buf_q[1]);
      if (local_commit && info_q.kind == K_CSUMEN)
        csum_q <= buf_q[1][0];
      if (clr) begin
        op_q   <= OP_IDLE;
        off_q  <= '0;
        info_q <= '0;
        for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'h00;
      end else if (rx_at_idx && lk_ok) begin
        op_q     <= OP_SEND;
        info_q   <= lk_info;
        buf_q[0] <= ev_rx_byte;
        off_q    <= OFF_W'(1);
      end else if (store_byte) begin
        buf_q[off_q] <= ev_rx_byte;
        off_q        <= off_q + OFF_W'(1);
      end else if (snap) begin
        op_q     <= OP_RECV;
        buf_q[1] <= rs_value[7:0];
        buf_q[2] <= rs_value[15:8];
        buf_q[3] <= rs_value[23:16];
        buf_q[4] <= rs_value[31:24];
        off_q    <= OFF_W'(2);
      end else if (seq_rd) begin
        off_q <= off_q + OFF_W'(1);
      end
      if (ev_tx_req) begin
        if (snap)         tx_byte <= rs_value[7:0];
        else if (fifo_rd) tx_byte <= dn_rdata[7:0];
        else if (seq_rd)  tx_byte <= seq_byte;
        else              tx_byte <= 8'hFF;
      end
    end
  end

endmodule

// File: rtl/regbridge_chk.sv
module regbridge_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int OFF_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_rx_valid,
  input logic             ev_tx_req,
  input logic             ev_stop,
  input logic             ev_rd_start,
  input logic             rx_nak,
  input logic             tx_valid,
  input logic             dn_wr,
  input logic             dn_rd,
  input logic [2:0]       dn_size,
  input logic [LOC_W-1:0] loc_q,
  input logic [OFF_W-1:0] off_q
);
  assert_nak_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nak |-> $past(ev_rx_valid));

  assert_wr_only_at_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_wr && !ev_rx_valid) |-> (ev_stop && dn_size == 3'd4));

  assert_stream_one_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_wr && ev_rx_valid) |-> (dn_size == 3'd1));

  assert_loc_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loc_q < LOC_W'(NUM_LOC));

  assert_rd_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rd |-> (ev_tx_req && !dn_wr));

  assert_tx_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_req |=> tx_valid);

  assert_rd_start_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_start && !ev_rx_valid && !ev_tx_req && !ev_stop) |=> $stable(off_q));

  assert_stop_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (off_q == '0));
endmodule

bind i2c_regbridge regbridge_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_rx_valid (ev_rx_valid),
  .ev_tx_req   (ev_tx_req),
  .ev_stop     (ev_stop),
  .ev_rd_start (ev_rd_start),
  .rx_nak      (rx_nak),
  .tx_valid    (tx_valid),
  .dn_wr       (dn_wr),
  .dn_rd       (dn_rd),
  .dn_size     (dn_size),
  .loc_q       (loc_q),
  .off_q       (off_q)
);

// File: tb/i2c_regbridge_tb.sv
module i2c_regbridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_wr_start = 0, ev_rd_start = 0, ev_rx_valid = 0, ev_tx_req = 0, ev_stop = 0;
  logic [7:0] ev_rx_byte = 8'h00;
  logic rx_done, rx_nak, tx_valid, dn_wr, dn_rd;
  logic [7:0] tx_byte;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata;
  logic [2:0] dn_size;
  logic [31:0] rd_xor = 32'h0;

  int total = 0, fails = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] last_waddr, last_raddr;
  logic [31:0] last_wdata;
  logic [2:0]  last_wsize, last_rsize;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_regbridge u_dut (
    .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
    .ev_rx_valid(ev_rx_valid), .ev_rx_byte(ev_rx_byte), .ev_tx_req(ev_tx_req),
    .ev_stop(ev_stop), .rx_done(rx_done), .rx_nak(rx_nak), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_size(dn_size),
    .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_rdata(dn_rdata)
  );

  // downstream model: a deterministic function of the address
  assign dn_rdata = {~dn_addr, dn_addr} ^ rd_xor;

  always @(posedge clk) begin
    cyc++;
    if (rst_n && dn_wr) begin wr_cnt++; last_waddr = dn_addr; last_wdata = dn_wdata; last_wsize = dn_size; end
    if (rst_n && dn_rd) begin rd_cnt++; last_raddr = dn_addr; last_rsize = dn_size; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_start(); @(negedge clk); ev_wr_start = 1; @(negedge clk); ev_wr_start = 0; endtask
  task automatic rd_start(); @(negedge clk); ev_rd_start = 1; @(negedge clk); ev_rd_start = 0; endtask
  task automatic stop();     @(negedge clk); ev_stop = 1;     @(negedge clk); ev_stop = 0;     endtask

  task automatic send(input logic [7:0] b, output logic nak);
    @(negedge clk); ev_rx_valid = 1; ev_rx_byte = b;
    @(negedge clk); ev_rx_valid = 0; nak = rx_nak;
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk); ev_tx_req = 1;
    @(negedge clk); ev_tx_req = 0; b = tx_byte;
  endtask

  task automatic reg_write(input logic [7:0] ix, input int n, input logic [31:0] v);
    logic nak;
    wr_start(); send(ix, nak);
    for (int i = 0; i < n; i++) send(v[8*i +: 8], nak);
    stop();
  endtask

  task automatic reg_read(input logic [7:0] ix, output logic [31:0] v);
    logic nak; logic [7:0] b;
    wr_start(); send(ix, nak); rd_start();
    for (int i = 0; i < 4; i++) begin recv(b); v[8*i +: 8] = b; end
    stop();
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [31:0] v;
    check("R13 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    check("R13 rx_nak after reset", {31'h0, rx_nak}, 32'h0);
    recv(b);
    check("R13 read with no index", {24'h0, b}, 32'hFF);
    check("R13 no bus read without index", rd_cnt, 0);
    reg_read(8'h00, v);
    check("R13 locality cleared by reset", v, 32'h0);
    reg_read(8'h40, v);
    check("R13 checksum enable cleared", v, 32'h0);
  endtask

  task automatic t_index();
    logic nak;
    wr_start(); send(8'h7E, nak); check("R1 unmapped index NAK", {31'h0, nak}, 32'h1); stop();
    wr_start(); send(8'h38, nak); check("R1 address-change index NAK", {31'h0, nak}, 32'h1); stop();
    wr_start(); send(8'h48, nak); check("R1 mapped index ACK", {31'h0, nak}, 32'h0); stop();
    check("R1 no bus traffic", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_word_write();
    logic nak; int w0;
    w0 = wr_cnt;
    wr_start(); send(8'h48, nak);
    send(8'h11, nak); send(8'h22, nak); send(8'h33, nak); send(8'h44, nak);
    check("R3 nothing before stop", wr_cnt - w0, 0);
    stop();
    check("R3 one write at stop", wr_cnt - w0, 1);
    check("R3 assembled LE word", last_wdata, 32'h4433_2211);
    check("R2 id address loc0", {16'h0, last_waddr}, 32'h0F00);
    check("R3 size 4", {29'h0, last_wsize}, 32'd4);
    reg_write(8'h4C, 2, 32'h0000_BEEF);
    check("R3 short write zero-filled", last_wdata, 32'h0000_BEEF);
  endtask

  task automatic t_fifo_write();
    logic nak; int w0;
    w0 = wr_cnt;
    wr_start(); send(8'h24, nak);
    send(8'hAA, nak);
    check("R4 immediate write", wr_cnt - w0, 1);
    check("R4 byte data", last_wdata, 32'hAA);
    check("R4 size 1", {29'h0, last_wsize}, 32'd1);
    send(8'hBB, nak); send(8'hCC, nak); send(8'hDD, nak); send(8'hEE, nak);
    check("R4 no NAK on long stream", {31'h0, nak}, 32'h0);
    stop();
    check("R4 one write per byte, none at stop", wr_cnt - w0, 5);
    check("R2 fifo address", {16'h0, last_waddr}, 32'h0024);
  endtask

  task automatic t_locality();
    logic [31:0] v; int w0;
    w0 = wr_cnt;
    reg_write(8'h00, 1, 32'h3);
    check("R5 locality write not forwarded", wr_cnt - w0, 0);
    reg_read(8'h00, v);
    check("R5 locality readback", v, 32'h3);
    reg_write(8'h00, 1, 32'h7);
    reg_read(8'h00, v);
    check("R5 invalid locality ignored", v, 32'h3);
    reg_write(8'h48, 4, 32'h1234_5678);
    check("R2 address includes locality", {16'h0, last_waddr}, 32'h3F00);
    reg_write(8'h00, 1, 32'h0);
  endtask

  task automatic t_csum();
    logic [31:0] v; int w0;
    w0 = wr_cnt;
    reg_write(8'h40, 1, 32'hFF);
    check("R6 checksum write not forwarded", wr_cnt - w0, 0);
    reg_read(8'h40, v);
    check("R6 only enable bit kept", v, 32'h1);
  endtask

  task automatic t_masks();
    logic [31:0] v; int r0;
    reg_write(8'h08, 4, 32'hFFFF_FFFF);
    check("R7 interrupt enable masked", last_wdata, 32'h8000_0087);
    r0 = rd_cnt;
    reg_read(8'h14, v);
    check("R7 capability value", v, 32'h8000_0087);
    check("R7 capability no bus read", rd_cnt - r0, 0);
    reg_write(8'h1B, 1, 32'hFF);
    check("R8 lane3 address", {16'h0, last_waddr}, 32'h001B);
    check("R8 lane3 mask", last_wdata, 32'h07);
    reg_write(8'h18, 4, 32'hFFFF_FFFF);
    check("R8 lane0 mask", last_wdata, 32'h0700_006E);
    check("R8 lane0 address", {16'h0, last_waddr}, 32'h0018);
  endtask

  task automatic t_sts_read();
    logic nak; logic [7:0] b; int r0;
    r0 = rd_cnt;
    wr_start(); send(8'h1A, nak); rd_start();
    recv(b); check("R10 lane2 byte0", {24'h0, b}, 32'hE7);
    check("R9 one capture read", rd_cnt - r0, 1);
    check("R2 status read address", {16'h0, last_raddr}, 32'h0018);
    recv(b); check("R10 lane2 byte1", {24'h0, b}, 32'h03);
    recv(b); check("R10 lane2 byte2", {24'h0, b}, 32'h00);
    recv(b); check("R9 byte3", {24'h0, b}, 32'h00);
    recv(b); check("R9 exhausted returns FF", {24'h0, b}, 32'hFF);
    check("R9 no further bus reads", rd_cnt - r0, 1);
    stop();
  endtask

  task automatic t_ifcap();
    logic [31:0] v;
    reg_read(8'h30, v);
    check("R11 fixed capability", v, 32'h0008_1292);
    rd_xor = 32'h100;
    reg_read(8'h30, v);
    check("R11 burst bit mirrored", v, 32'h2008_1292);
    rd_xor = 32'h0;
  endtask

  task automatic t_fifo_read();
    logic nak; logic [7:0] b; int r0;
    r0 = rd_cnt;
    wr_start(); send(8'h24, nak); rd_start();
    rd_xor = 32'h10; recv(b); check("R12 fifo byte0", {24'h0, b}, 32'h34);
    check("R12 one-byte size", {29'h0, last_rsize}, 32'd1);
    rd_xor = 32'h20; recv(b); check("R12 fifo byte1 fresh", {24'h0, b}, 32'h04);
    rd_xor = 32'h30; recv(b); check("R12 fifo byte2 fresh", {24'h0, b}, 32'h14);
    check("R12 read per byte", rd_cnt - r0, 3);
    rd_xor = 32'h0;
    stop();
  endtask

  task automatic t_overflow_restart();
    logic nak; int w0;
    wr_start(); send(8'h48, nak);
    send(8'h01, nak); send(8'h02, nak); send(8'h03, nak); send(8'h04, nak);
    check("R14 fourth byte accepted", {31'h0, nak}, 32'h0);
    send(8'h05, nak);
    check("R14 fifth byte NAK", {31'h0, nak}, 32'h1);
    stop();
    check("R14 overflow byte dropped", last_wdata, 32'h0403_0201);
    w0 = wr_cnt;
    wr_start(); send(8'h48, nak); send(8'hA1, nak); send(8'hA2, nak);
    wr_start(); send(8'h4C, nak); send(8'h09, nak);
    stop();
    check("R13 restart discards first", wr_cnt - w0, 1);
    check("R13 restart word", last_wdata, 32'h0000_0009);
    check("R13 restart address", {16'h0, last_waddr}, 32'h0F04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_word_write();
    t_fifo_write();
    t_locality();
    t_csum();
    t_masks();
    t_sts_read();
    t_ifcap();
    t_fifo_read();
    t_overflow_restart();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 100000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule